// File: doc/BRIEF.md
# User-Level Profiling Timer Trap

This block is a per-thread countdown timer that lets a program profile itself without a system call. Software loads a cycle count, a handler entry address and a stack skip amount. When the count runs out, the block raises a redirect request to instruction fetch. The request carries the handler address, the address at which the interrupted code should resume, and a new stack pointer. The new stack pointer has already been lowered past the calling convention's red zone, so the handler cannot overwrite the interrupted code's scratch area below the stack pointer. No privilege change takes place.

The request is held until fetch acknowledges it. A handler-active flag masks further traps until software clears it, so traps never nest. An expiry that happens while a request is still waiting is discarded. Writing a count of zero switches the timer off; it does not fire a trap.

Top module: `uprof_timer_trap`

## Requirements
- R1: A write to selector 0 loads the counter. After that, the counter goes down by one on each clock while it is nonzero. Reading selector 0 returns the counter, zero-extended.
- R2: Writing 0 to selector 0 stops the timer. No redirect follows, and the counter stays at 0.
- R3: The redirect is raised N clock edges after the edge that writes count N (N ≥ 1). redir_target equals the value of the handler register (selector 1) at the moment of expiry.
- R4: redir_sp equals cur_sp at expiry minus the skip register (selector 2), modulo 2^XLEN.
- R5: resume_pc at the expiry edge is captured. It appears on redir_resume and can be read at selector 3.
- R6: A trap sets handler_active. Expiries that occur while handler_active is set raise no redirect. Any write to selector 3 clears handler_active.
- R7: While redir_valid is high and redir_ack is low, the request and its three values stay unchanged. An ack drops redir_valid on the next edge.
- R8: An expiry that occurs while a request is still pending is dropped. It leaves the pending request and the resume address unchanged, and it does not set handler_active.
- R9: A write to one selector changes only that register. A write to selector 3 leaves the captured resume address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector: 0 count, 1 handler, 2 skip, 3 resume/clear |
| cfg_wdata | input | XLEN | Write data |
| cfg_rdata | output | XLEN | Read data for cfg_sel |
| resume_pc | input | XLEN | Address of the next instruction to resume at |
| cur_sp | input | XLEN | Current stack pointer |
| redir_ack | input | 1 | Fetch accepts the redirect |
| redir_valid | output | 1 | Redirect request pending |
| redir_target | output | XLEN | Handler entry address |
| redir_resume | output | XLEN | Saved resumption address |
| redir_sp | output | XLEN | Stack pointer lowered past the red zone |
| handler_active | output | 1 | Handler running; traps masked |

## Verification
The hardest case to reach is a second expiry while a request is still pending but handler_active is already clear. Normally, the flag set by the first trap masks the second expiry before the pending check matters. The bench builds this case on purpose: it lets a trap fire, withholds the ack, clears the flag through selector 3, and reloads a count of 1. It then confirms that the new resume_pc is not taken and the flag stays clear. Random cycles mix short counts, late acks and clears, so expiry lands next to acks and writes in many different orders.

// File: rtl/uprof_pkg.sv
package uprof_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_HANDLER = 2'd1,
    SEL_SKIP    = 2'd2,
    SEL_RESUME  = 2'd3
  } uprof_sel_e;
endpackage

// File: rtl/uprof_countdown.sv
module uprof_countdown #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // A load always wins over the decrement.
  // The step from one to zero is the expiry.
  always_comb begin
    cnt_en = load_en || (cnt_q != CNT_ZERO);
    expire = (cnt_q == CNT_ONE) && !load_en;
    if (load_en) cnt_d = load_val;
    else         cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uprof_ctx_regs.sv
module uprof_ctx_regs #(
  parameter int XLEN   = 32,
  parameter int SKIP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_handler,
  input  logic              wr_skip,
  input  logic              wr_clear,
  input  logic [XLEN-1:0]   wdata,
  input  logic              take,
  input  logic [XLEN-1:0]   pc_in,
  output logic [XLEN-1:0]   handler_q,
  output logic [SKIP_W-1:0] skip_q,
  output logic [XLEN-1:0]   resume_q,
  output logic              active_q
);
  logic active_d, active_en;

  always_comb begin
    active_en = take || wr_clear;
    active_d  = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) handler_q <= '0;
    else if (wr_handler) handler_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= '0;
    else if (wr_skip) skip_q <= wdata[SKIP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resume_q <= '0;
    else if (take) resume_q <= pc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else if (active_en) active_q <= active_d;
  end
endmodule

// File: rtl/uprof_redirect.sv
module uprof_redirect #(
  parameter int XLEN   = 32,
  parameter int SKIP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              active,
  input  logic              ack,
  input  logic [XLEN-1:0]   handler,
  input  logic [SKIP_W-1:0] skip,
  input  logic [XLEN-1:0]   sp_in,
  output logic              take,
  output logic              valid_q,
  output logic [XLEN-1:0]   target_q,
  output logic [XLEN-1:0]   sp_q
);
  localparam int PAD_W = XLEN - SKIP_W;

  logic            valid_d, valid_en;
  logic [XLEN-1:0] sp_adj;

  always_comb begin
    take     = expire && !active && !valid_q;
    sp_adj   = sp_in - {{PAD_W{1'b0}}, skip};
    valid_en = take || (valid_q && ack);
    valid_d  = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else if (valid_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      sp_q     <= '0;
    end else if (take) begin
      target_q <= handler;
      sp_q     <= sp_adj;
    end
  end
endmodule

// File: rtl/uprof_timer_trap.sv
module uprof_timer_trap
  import uprof_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CNT_W  = 24,
  parameter int SKIP_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [XLEN-1:0] cfg_wdata,
  output logic [XLEN-1:0] cfg_rdata,
  input  logic [XLEN-1:0] resume_pc,
  input  logic [XLEN-1:0] cur_sp,
  input  logic            redir_ack,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_target,
  output logic [XLEN-1:0] redir_resume,
  output logic [XLEN-1:0] redir_sp,
  output logic            handler_active
);
  localparam int CNT_PAD  = XLEN - CNT_W;
  localparam int SKIP_PAD = XLEN - SKIP_W;

  uprof_sel_e        sel;
  logic              cnt_load, wr_handler, wr_skip, wr_clear;
  logic              expire, take;
  logic [CNT_W-1:0]  cnt_q;
  logic [XLEN-1:0]   handler_q;
  logic [SKIP_W-1:0] skip_q;

  always_comb begin
    sel        = uprof_sel_e'(cfg_sel);
    cnt_load   = cfg_we && (sel == SEL_COUNT);
    wr_handler = cfg_we && (sel == SEL_HANDLER);
    wr_skip    = cfg_we && (sel == SEL_SKIP);
    wr_clear   = cfg_we && (sel == SEL_RESUME);
  end

  uprof_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load_en(cnt_load),
    .load_val(cfg_wdata[CNT_W-1:0]), .cnt_q(cnt_q), .expire(expire)
  );

  uprof_ctx_regs #(.XLEN(XLEN), .SKIP_W(SKIP_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .wr_handler(wr_handler), .wr_skip(wr_skip),
    .wr_clear(wr_clear), .wdata(cfg_wdata), .take(take), .pc_in(resume_pc),
    .handler_q(handler_q), .skip_q(skip_q), .resume_q(redir_resume),
    .active_q(handler_active)
  );

  uprof_redirect #(.XLEN(XLEN), .SKIP_W(SKIP_W)) u_redir (
    .clk(clk), .rst_n(rst_n), .expire(expire), .active(handler_active),
    .ack(redir_ack), .handler(handler_q), .skip(skip_q), .sp_in(cur_sp),
    .take(take), .valid_q(redir_valid), .target_q(redir_target), .sp_q(redir_sp)
  );

  always_comb begin
    unique case (sel)
      SEL_COUNT:   cfg_rdata = {{CNT_PAD{1'b0}}, cnt_q};
      SEL_HANDLER: cfg_rdata = handler_q;
      SEL_SKIP:    cfg_rdata = {{SKIP_PAD{1'b0}}, skip_q};
      default:     cfg_rdata = redir_resume;
    endcase
  end
endmodule

// File: rtl/uprof_trap_checker.sv
module uprof_trap_checker #(
  parameter int XLEN   = 32,
  parameter int CNT_W  = 24,
  parameter int SKIP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_load,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [XLEN-1:0]   handler_q,
  input logic [SKIP_W-1:0] skip_q,
  input logic [XLEN-1:0]   cur_sp,
  input logic              redir_ack,
  input logic              redir_valid,
  input logic [XLEN-1:0]   redir_target,
  input logic [XLEN-1:0]   redir_resume,
  input logic [XLEN-1:0]   redir_sp,
  input logic              handler_active
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CNT_W'(1)) && !cnt_load |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R1
  AST_IDLE_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) && !cnt_load |=> cnt_q == '0); // R2
  AST_TARGET_FROM_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) |-> redir_target == $past(handler_q)); // R3
  AST_SP_SKIPS_REDZONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) |-> redir_sp == $past(cur_sp) - XLEN'($past(skip_q))); // R4
  AST_NO_NESTED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) |-> !$past(handler_active) && handler_active); // R6
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && !redir_ack |=> redir_valid && $stable(redir_target) && $stable(redir_sp)); // R7
  AST_PENDING_KEEPS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> $stable(redir_resume)); // R8
endmodule

bind uprof_timer_trap uprof_trap_checker #(.XLEN(XLEN), .CNT_W(CNT_W), .SKIP_W(SKIP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .cnt_q(cnt_q),
  .handler_q(handler_q), .skip_q(skip_q), .cur_sp(cur_sp), .redir_ack(redir_ack),
  .redir_valid(redir_valid), .redir_target(redir_target), .redir_resume(redir_resume),
  .redir_sp(redir_sp), .handler_active(handler_active)
);

// File: tb/uprof_timer_trap_bench.sv
`timescale 1ns/1ps
module uprof_timer_trap_bench;
  logic        clk, rst_n;
  logic        cfg_we, redir_ack;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata, resume_pc, cur_sp;
  logic        redir_valid, handler_active;
  logic [31:0] redir_target, redir_resume, redir_sp;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic [23:0] m_cnt;
  logic [31:0] m_hdl, m_res, m_tgt, m_sp;
  logic [11:0] m_skip;
  logic        m_act, m_v;

  uprof_timer_trap u_uprof_timer_trap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .resume_pc(resume_pc),
    .cur_sp(cur_sp), .redir_ack(redir_ack), .redir_valid(redir_valid),
    .redir_target(redir_target), .redir_resume(redir_resume),
    .redir_sp(redir_sp), .handler_active(handler_active)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [1:0] s);
    case (s)
      2'd0: return {8'h0, m_cnt};
      2'd1: return m_hdl;
      2'd2: return {20'h0, m_skip};
      default: return m_res;
    endcase
  endfunction

  task automatic compare_all();
    chk("R3 valid", {31'h0, redir_valid}, {31'h0, m_v});
    chk("R3 target", redir_target, m_tgt);
    chk("R4 sp", redir_sp, m_sp);
    chk("R5 resume", redir_resume, m_res);
    chk("R6 active", {31'h0, handler_active}, {31'h0, m_act});
    chk(cfg_sel == 2'd0 ? "R1 rdata" : "R9 rdata", cfg_rdata, exp_rdata(cfg_sel));
  endtask

  // Advance the reference by one edge, using the inputs now applied.
  task automatic model_step();
    logic ld, fire, tk;
    ld   = cfg_we && cfg_sel == 2'd0;
    fire = (m_cnt == 24'd1) && !ld;
    tk   = fire && !m_act && !m_v;
    if (tk) begin
      m_tgt = m_hdl; m_sp = cur_sp - {20'h0, m_skip}; m_res = resume_pc;
    end
    if (tk) m_act = 1'b1;
    else if (cfg_we && cfg_sel == 2'd3) m_act = 1'b0;
    if (tk) m_v = 1'b1;
    else if (m_v && redir_ack) m_v = 1'b0;
    if (ld) m_cnt = cfg_wdata[23:0];
    else if (m_cnt != 0) m_cnt = m_cnt - 24'd1;
    if (cfg_we && cfg_sel == 2'd1) m_hdl = cfg_wdata;
    if (cfg_we && cfg_sel == 2'd2) m_skip = cfg_wdata[11:0];
  endtask

  task automatic cyc(input bit we, input logic [1:0] s, input logic [31:0] d,
                     input bit ack, input logic [31:0] pc, input logic [31:0] sp);
    cfg_we = we; cfg_sel = s; cfg_wdata = d; redir_ack = ack;
    resume_pc = pc; cur_sp = sp;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n, input logic [31:0] pc, input logic [31:0] sp);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 32'h0, 0, pc, sp);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; redir_ack = 0; resume_pc = 0; cur_sp = 0;
    m_cnt = 0; m_hdl = 0; m_res = 0; m_tgt = 0; m_sp = 0; m_skip = 0; m_act = 0; m_v = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    for (int s = 0; s < 4; s++) begin
      cfg_sel = 2'(s); #1;
      chk("R9 reset rdata", cfg_rdata, 32'h0);
    end
    chk("R3 reset valid", {31'h0, redir_valid}, 32'h0);
    chk("R6 reset active", {31'h0, handler_active}, 32'h0);

    // basic trap: count 3, expires on third edge after the load edge
    cyc(1, 2'd1, 32'h1000_0400, 0, 32'h0, 32'h0);
    cyc(1, 2'd2, 32'h0000_0080, 0, 32'h0, 32'h0);
    cyc(1, 2'd0, 32'd3, 0, 32'h0, 32'h0);
    idle(2, 32'h0000_AAA0, 32'h8000);
    chk("R3 not yet", {31'h0, redir_valid}, 32'h0);
    idle(1, 32'h0000_AAA0, 32'h8000);
    chk("R3 fires", {31'h0, redir_valid}, 32'h1);
    chk("R3 target", redir_target, 32'h1000_0400);
    chk("R4 sp", redir_sp, 32'h0000_7F80);
    chk("R5 resume", redir_resume, 32'h0000_AAA0);
    chk("R6 set", {31'h0, handler_active}, 32'h1);
    // hold until acked; handler rewrite must not disturb the request
    cyc(1, 2'd1, 32'hDEAD_0000, 0, 32'h1, 32'h2);
    idle(1, 32'h3, 32'h4);
    chk("R7 held", redir_target, 32'h1000_0400);
    chk("R7 held valid", {31'h0, redir_valid}, 32'h1);
    cyc(0, 2'd0, 32'h0, 1, 32'h0, 32'h0);
    chk("R7 ack drops", {31'h0, redir_valid}, 32'h0);

    // masked while active
    cyc(1, 2'd0, 32'd2, 0, 32'h0, 32'h0);
    idle(3, 32'h5555, 32'h0);
    chk("R6 masked", {31'h0, redir_valid}, 32'h0);
    chk("R6 masked resume", redir_resume, 32'h0000_AAA0);
    cyc(1, 2'd3, 32'hFFFF_FFFF, 0, 32'h0, 32'h0);
    chk("R6 cleared", {31'h0, handler_active}, 32'h0);
    cfg_sel = 2'd3; #1;
    chk("R9 clear keeps resume", cfg_rdata, 32'h0000_AAA0);

    // dropped expiry while pending, active already cleared
    cyc(1, 2'd0, 32'd1, 0, 32'h0, 32'h0);
    idle(1, 32'h0000_BBB0, 32'h100);
    chk("R5 second trap", redir_resume, 32'h0000_BBB0);
    cyc(1, 2'd3, 32'h0, 0, 32'h0, 32'h0);
    cyc(1, 2'd0, 32'd1, 0, 32'h0, 32'h0);
    idle(1, 32'h0000_CCC0, 32'h200);
    chk("R8 resume kept", redir_resume, 32'h0000_BBB0);
    chk("R8 active not set", {31'h0, handler_active}, 32'h0);
    chk("R8 still pending", {31'h0, redir_valid}, 32'h1);
    cyc(0, 2'd0, 32'h0, 1, 32'h0, 32'h0);

    // zero disables
    cyc(1, 2'd0, 32'd0, 0, 32'h0, 32'h0);
    idle(8, 32'h7, 32'h7);
    chk("R2 zero idle", {31'h0, redir_valid}, 32'h0);
    cyc(1, 2'd0, 32'd5, 0, 32'h0, 32'h0);
    idle(2, 32'h7, 32'h7);
    cyc(1, 2'd0, 32'd0, 0, 32'h0, 32'h0);
    idle(6, 32'h7, 32'h7);
    chk("R2 stopped", {31'h0, redir_valid}, 32'h0);
    chk("R2 count zero", cfg_rdata, 32'h0);

    // stack wrap
    cyc(1, 2'd2, 32'h0000_0080, 0, 32'h0, 32'h0);
    cyc(1, 2'd0, 32'd1, 0, 32'h0, 32'h0);
    idle(1, 32'h9, 32'h10);
    chk("R4 wrap", redir_sp, 32'hFFFF_FF90);
    cyc(0, 2'd0, 32'h0, 1, 32'h0, 32'h0);
    cyc(1, 2'd3, 32'h0, 0, 32'h0, 32'h0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [1:0] s;
      logic [31:0] d;
      bit we;
      r = $urandom_range(0, 99);
      we = 1; d = $urandom;
      if (r < 12) begin s = 2'd0; d = 32'($urandom_range(0, 6)); end
      else if (r < 16) s = 2'd1;
      else if (r < 20) s = 2'd2;
      else if (r < 28) s = 2'd3;
      else begin we = 0; s = 2'($urandom_range(0, 3)); end
      cyc(we, s, d, ($urandom_range(0, 99) < 35), $urandom, $urandom);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule